// File: doc/BRIEF.md
# Interrupt Sensitivity Configuration and Pending Detection

This block holds the trigger configuration for 96 interrupt lines, numbered 0 to 95, and turns each enabled line into a pending bit. Every line owns a 2-bit code. Six 32-bit registers hold these codes, sixteen lines per register. The registers sit behind a simple port: a write strobe, an address and a combinational read.

Lines 32 to 95 are the shared sources. Software selects for each one either active-high level or rising-edge detection. Lines 0 to 31 carry fixed codes that software cannot change. Among them, the software lines never become pending here, and five private lines have built-in detection. Four shared IDs are reserved and stay silent.

Each input passes through a synchronizer before detection. An edge-detected pending bit stays set until its per-line clear strobe is pulsed. Arbitration, CPU routing and acknowledge are left to the blocks downstream.

Top module: `irq_sense_top`

## Requirements
- R1: Line n's code sits in register n/16 at bits [2*(n%16)+1 : 2*(n%16)], with registers at addresses 0 to 5. Addresses 6 and 7 read zero and ignore writes.
- R2: For a shared line, code 01 selects active-high level and code 11 selects rising edge. Writing 00 or 10 into a shared field leaves its previous code unchanged.
- R3: After reset every shared non-reserved field reads 01 and every pending bit is 0.
- R4: Register 0 always reads 0xAAAAAAAA and register 1 always reads 0x7DC00000. Writes to them are ignored.
- R5: IDs 36, 93, 94 and 95 read 00, ignore writes, and never become pending.
- R6: In level mode a pending bit equals the synchronized input, with SYNC_STAGES+1 cycles of latency from the input. A clear strobe has no effect on it.
- R7: In edge mode a rising input sets the pending bit after SYNC_STAGES+1 cycles. The bit stays set after the input falls, and a clear strobe drops it at the next clock.
- R8: In edge mode, clearing while the input stays high leaves the bit at 0 until a new rising edge arrives.
- R9: Private lines 27, 29 and 30 are rising-edge and lines 28 and 31 are active-low level, all ignoring configuration writes. Lines 0 to 26 never become pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Combinational read data for cfgAddr |
| irqIn | input | 96 | Raw interrupt lines, one per ID |
| irqClr | input | 96 | Per-line pending clear strobes |
| irqPend | output | 96 | Pending bits, one per ID |

## Verification
A corrupted stored code shows on the read port in the same cycle. It also changes how the line reacts to its next input change: a pending bit that fails to hold after the input falls, or one that follows the input when it should latch. An error in the synchronizer or edge register moves the pending change away from the SYNC_STAGES+1 cycle point, so the pending vector is sampled one cycle early and exactly on time. Reserved and fixed lines are driven active, and the full pending vector is compared, so a stray bit on any of them is caught.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int NUM_IDS      = 96;
  localparam int FIELD_W      = 2;
  localparam int REG_W        = 32;
  localparam int IDS_PER_REG  = REG_W / FIELD_W;
  localparam int NUM_REGS     = NUM_IDS / IDS_PER_REG;
  localparam int ADDR_W       = 3;
  localparam int FIRST_SHARED = 32;
  localparam int FIRST_PRIV   = 16;

  localparam logic [FIELD_W-1:0] CODE_OFF   = 2'b00;
  localparam logic [FIELD_W-1:0] CODE_LEVEL = 2'b01;
  localparam logic [FIELD_W-1:0] CODE_SOFT  = 2'b10;
  localparam logic [FIELD_W-1:0] CODE_EDGE  = 2'b11;

  typedef struct packed {
    logic [NUM_IDS-1:0] fieldWe;
    logic [REG_W-1:0]   wrWord;
  } cfgStrobe_t;

  function automatic logic isReserved(int id);
    return (id == 36) || (id >= 93);
  endfunction

  function automatic logic isShared(int id);
    return (id >= FIRST_SHARED) && !isReserved(id);
  endfunction

  function automatic logic [FIELD_W-1:0] fixedCode(int id);
    if (id < FIRST_PRIV) return CODE_SOFT;
    if (id == 27 || id == 29 || id == 30) return CODE_EDGE;
    if (id == 28 || id == 31) return CODE_LEVEL;
    return CODE_OFF;
  endfunction

  function automatic logic hasDetector(int id);
    if (isShared(id)) return 1'b1;
    return (id >= FIRST_PRIV) && (id < FIRST_SHARED) && (fixedCode(id) != CODE_OFF);
  endfunction
endpackage

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [ADDR_W-1:0]          cfgAddr,
  input  logic [REG_W-1:0]           cfgWdata,
  input  logic [NUM_IDS*FIELD_W-1:0] cfgStore,
  output cfgStrobe_t                 strobe,
  output logic [REG_W-1:0]           cfgRdata
);
  logic [NUM_IDS-1:0]         fieldWeVec;
  logic [NUM_IDS*FIELD_W-1:0] readFields;

  for (genvar id = 0; id < NUM_IDS; id++) begin : g_field
    localparam int SLOT = id % IDS_PER_REG;
    localparam logic [ADDR_W-1:0] REG_SEL = ADDR_W'(id / IDS_PER_REG);
    if (isShared(id)) begin : g_rw
      logic [FIELD_W-1:0] codeIn;
      assign codeIn = cfgWdata[SLOT*FIELD_W +: FIELD_W];
      assign fieldWeVec[id] = cfgWe && (cfgAddr == REG_SEL) &&
                              ((codeIn == CODE_LEVEL) || (codeIn == CODE_EDGE));
      assign readFields[id*FIELD_W +: FIELD_W] = cfgStore[id*FIELD_W +: FIELD_W];
    end else if (id < FIRST_SHARED) begin : g_fixed
      assign fieldWeVec[id] = 1'b0;
      assign readFields[id*FIELD_W +: FIELD_W] = fixedCode(id);
    end else begin : g_rsv
      assign fieldWeVec[id] = 1'b0;
      assign readFields[id*FIELD_W +: FIELD_W] = CODE_OFF;
    end
  end

  assign strobe = '{fieldWe: fieldWeVec, wrWord: cfgWdata};

  always_comb begin
    cfgRdata = '0;
    if (int'(cfgAddr) < NUM_REGS) cfgRdata = readFields[int'(cfgAddr)*REG_W +: REG_W];
  end

  AST_WE_FROM_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (|fieldWeVec) |-> cfgWe); // R1
  AST_FIXED_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 3'd1) |-> (cfgRdata == 32'h7DC0_0000)); // R4
endmodule

// File: rtl/irq_sense_dp.sv
module irq_sense_dp
  import irq_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobe_t                 strobe,
  input  logic [NUM_IDS-1:0]         irqIn,
  input  logic [NUM_IDS-1:0]         irqClr,
  output logic [NUM_IDS*FIELD_W-1:0] cfgStore,
  output logic [NUM_IDS-1:0]         irqPend
);
  logic [NUM_IDS-1:0] modeEdge;

  for (genvar id = 0; id < NUM_IDS; id++) begin : g_cfg
    localparam int SLOT = id % IDS_PER_REG;
    if (isShared(id)) begin : g_store
      logic [FIELD_W-1:0] cfgQ;
      always_ff @(posedge clk) begin
        if (!rstN) cfgQ <= CODE_LEVEL;
        else if (strobe.fieldWe[id]) cfgQ <= strobe.wrWord[SLOT*FIELD_W +: FIELD_W];
      end
      assign cfgStore[id*FIELD_W +: FIELD_W] = cfgQ;
      assign modeEdge[id] = (cfgQ == CODE_EDGE);
      AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
        (cfgQ == CODE_LEVEL) || (cfgQ == CODE_EDGE)); // R2
    end else begin : g_const
      assign cfgStore[id*FIELD_W +: FIELD_W] = CODE_OFF;
      assign modeEdge[id] = (fixedCode(id) == CODE_EDGE);
    end
  end

  for (genvar id = 0; id < NUM_IDS; id++) begin : g_det
    if (hasDetector(id)) begin : g_on
      localparam logic INV = !isShared(id) && (fixedCode(id) == CODE_LEVEL);
      logic [SYNC_STAGES-1:0] syncQ;
      logic prevQ, pendQ, lvl, rise;
      assign lvl  = syncQ[SYNC_STAGES-1] ^ INV;
      assign rise = lvl && !prevQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncQ <= {SYNC_STAGES{INV}};
          prevQ <= 1'b0;
          pendQ <= 1'b0;
        end else begin
          syncQ[0] <= irqIn[id];
          for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
          prevQ <= lvl;
          if (modeEdge[id]) pendQ <= (pendQ && !irqClr[id]) || rise;
          else              pendQ <= lvl;
        end
      end
      assign irqPend[id] = pendQ;

      AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (modeEdge[id] && pendQ && !irqClr[id] && !strobe.fieldWe[id]) |=> pendQ); // R7
      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
        (!modeEdge[id] && lvl && !strobe.fieldWe[id]) |=> pendQ); // R6
      AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rstN)
        (modeEdge[id] && !pendQ && !rise && !strobe.fieldWe[id]) |=> !pendQ); // R8
    end else begin : g_off
      assign irqPend[id] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top
  import irq_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [REG_W-1:0]   cfgWdata,
  output logic [REG_W-1:0]   cfgRdata,
  input  logic [NUM_IDS-1:0] irqIn,
  input  logic [NUM_IDS-1:0] irqClr,
  output logic [NUM_IDS-1:0] irqPend
);
  cfgStrobe_t                 strobe;
  logic [NUM_IDS*FIELD_W-1:0] cfgStore;

  irq_sense_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgStore(cfgStore), .strobe(strobe), .cfgRdata(cfgRdata)
  );

  irq_sense_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqIn(irqIn), .irqClr(irqClr),
    .cfgStore(cfgStore), .irqPend(irqPend)
  );
endmodule

// File: tb/sim_irq_sense_top.sv
`timescale 1ns/1ps
module sim_irq_sense_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [2:0]  cfgAddr;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata;
  logic [95:0] irqIn, irqClr, irqPend;
  logic [95:0] model;

  typedef struct {
    int          at;
    bit          isRd;
    logic [31:0] rd;
    logic [95:0] pend;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_sense_top u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .irqIn(irqIn), .irqClr(irqClr), .irqPend(irqPend)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expRd(logic [2:0] a, logic [31:0] exp, string tag);
    item_t it;
    cfgAddr = a;
    it.at = cyc; it.isRd = 1; it.rd = exp; it.pend = '0; it.tag = tag;
    q.push_back(it);
    tick(1);
  endtask

  task automatic expPend(string tag);
    item_t it;
    it.at = cyc; it.isRd = 0; it.rd = '0; it.pend = model; it.tag = tag;
    q.push_back(it);
    tick(1);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cfgWe = 1; cfgAddr = a; cfgWdata = d;
    tick(1);
    cfgWe = 0;
  endtask

  task automatic clrPulse(int id);
    irqClr[id] = 1'b1;
    tick(1);
    irqClr[id] = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].at <= cyc) begin
        it = q.pop_front();
        applied++;
        if (it.isRd) begin
          if (cfgRdata !== it.rd) begin
            miscompares++;
            $display("FAIL %s read: actual %h expected %h", it.tag, cfgRdata, it.rd);
          end
        end else if (irqPend !== it.pend) begin
          miscompares++;
          $display("FAIL %s pending: actual %h expected %h", it.tag, irqPend, it.pend);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin : driver
    rstN = 0; cfgWe = 0; cfgAddr = 0; cfgWdata = 0; irqClr = '0; irqIn = '0;
    irqIn[28] = 1'b1; irqIn[31] = 1'b1;
    model = '0;
    tick(3);
    rstN = 1;
    tick(1);

    // R3 and R4 and R5: reset view
    expPend("R3");
    expRd(3'd0, 32'hAAAA_AAAA, "R4");
    expRd(3'd1, 32'h7DC0_0000, "R4");
    expRd(3'd2, 32'h5555_5455, "R5");
    expRd(3'd3, 32'h5555_5555, "R3");
    expRd(3'd4, 32'h5555_5555, "R3");
    expRd(3'd5, 32'h0155_5555, "R5");
    expRd(3'd6, 32'h0, "R1");

    // R6: level mode on ID 40
    irqIn[40] = 1'b1;
    tick(LAT - 1);
    expPend("R6");
    model[40] = 1'b1;
    expPend("R6");
    clrPulse(40);
    expPend("R6");
    irqIn[40] = 1'b0;
    tick(LAT);
    model[40] = 1'b0;
    expPend("R6");

    // R2, R5: ID40 to edge, attempt ID36; ID48 reserved code, ID49 edge
    wr(3'd2, 32'h5557_5755);
    expRd(3'd2, 32'h5557_5455, "R5");
    wr(3'd3, 32'h5555_555C);
    expRd(3'd3, 32'h5555_555D, "R2");

    // R7: edge sticky and clear
    irqIn[40] = 1'b1;
    tick(LAT);
    model[40] = 1'b1;
    expPend("R7");
    irqIn[40] = 1'b0;
    tick(LAT + 1);
    expPend("R7");
    clrPulse(40);
    model[40] = 1'b0;
    expPend("R7");

    // R8: clear while input held high
    irqIn[40] = 1'b1;
    tick(LAT);
    model[40] = 1'b1;
    expPend("R8");
    clrPulse(40);
    model[40] = 1'b0;
    expPend("R8");
    tick(LAT);
    expPend("R8");
    irqIn[40] = 1'b0;
    tick(LAT);

    // R2: ID48 kept level, ID49 edge
    irqIn[48] = 1'b1; irqIn[49] = 1'b1;
    tick(LAT);
    model[48] = 1'b1; model[49] = 1'b1;
    expPend("R2");
    irqIn[48] = 1'b0; irqIn[49] = 1'b0;
    tick(LAT);
    model[48] = 1'b0;
    expPend("R2");
    clrPulse(49);
    model[49] = 1'b0;

    // R1: field position, ID67 at register 4 bits 7:6
    wr(3'd4, 32'h5555_55D5);
    expRd(3'd4, 32'h5555_55D5, "R1");
    irqIn[67] = 1'b1;
    tick(LAT);
    model[67] = 1'b1;
    expPend("R1");
    irqIn[67] = 1'b0;
    tick(LAT);
    expPend("R1");
    clrPulse(67);
    model[67] = 1'b0;

    // R5, R9: reserved, software and unused private lines stay silent
    irqIn[36] = 1'b1; irqIn[95:93] = 3'b111; irqIn[3] = 1'b1; irqIn[20] = 1'b1;
    tick(LAT + 1);
    expPend("R5");
    wr(3'd5, 32'hFFFF_FFFF);
    expRd(3'd5, 32'h03FF_FFFF, "R5");
    irqIn[36] = 1'b0; irqIn[95:93] = 3'b000; irqIn[3] = 1'b0; irqIn[20] = 1'b0;

    // R4: fixed registers ignore writes
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    expRd(3'd0, 32'hAAAA_AAAA, "R4");
    expRd(3'd1, 32'h7DC0_0000, "R4");

    // R1: unmapped addresses
    wr(3'd7, 32'hFFFF_FFFF);
    expRd(3'd7, 32'h0, "R1");
    expRd(3'd6, 32'h0, "R1");

    // R9: private edge line 27 and active-low level line 28
    irqIn[27] = 1'b1;
    tick(LAT);
    model[27] = 1'b1;
    expPend("R9");
    irqIn[27] = 1'b0;
    tick(LAT);
    expPend("R9");
    clrPulse(27);
    model[27] = 1'b0;
    expPend("R9");
    irqIn[28] = 1'b0;
    tick(LAT);
    model[28] = 1'b1;
    expPend("R9");
    irqIn[28] = 1'b1;
    tick(LAT);
    model[28] = 1'b0;
    expPend("R9");

    tick(3);
    summary();
  end
endmodule